// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This unit sits beside a cache data RAM that has a registered read port and a write port that commits a store one cycle after that store's lookup. A load presents its row index in one cycle and receives the raw RAM word in the next. The two stores that came just before the load may not be in that word yet. The unit keeps those two stores in a short register chain. Each entry holds a valid flag, a row index, an 8-bit lane mask and 64 bits of data. The unit corrects the raw RAM word byte by byte, so the load always sees the stores that came before it.

The store port carries only store hits, the accesses that will be written into the RAM. A store on the port in cycle t goes into the younger entry at the edge that ends cycle t. It moves to the older entry one edge later. A load row on the port in cycle t is registered at the same edge. Its corrected word appears on `ld_data` during cycle t+1, combinationally from `ram_rdata`. So the load is forwarded from the stores that were on the port in cycle t and in cycle t-1. A store from cycle t-2 or earlier is already in the RAM word and is not forwarded.

Top module: `store_load_fwd`

## Requirements
- R1: Synchronous active-high reset empties both entries. In the first cycle after reset is released, `ld_data` equals `ram_rdata`, even if matching stores were driven while reset was high.
- R2: When no entry matches the registered load row, `ld_data` equals `ram_rdata` in the same cycle. A change of `ram_rdata` appears on `ld_data` with no clock edge.
- R3: A valid store on the port in the same cycle as the load row replaces, in `ld_data` of the next cycle, each byte lane b (bits 8b+7..8b) whose bit b of `st_mask` is 1. The other lanes keep the `ram_rdata` bytes.
- R4: A valid store on the port one cycle before the load row is forwarded in the same way, on the lanes its mask enables.
- R5: When both stores match the load row, each lane takes the byte of the younger store (the one in the load's own cycle) if that store enables the lane. Otherwise it takes the older store's byte if the older store enables it, and otherwise the `ram_rdata` byte.
- R6: A store whose `st_row` differs from the load row has no effect on that load's `ld_data`.
- R7: A store presented with `st_valid` low has no effect, whatever its row, mask and data.
- R8: A store presented two or more cycles before the load row is not forwarded.
- R9: A valid matching store with an all-zero `st_mask` leaves every lane at the `ram_rdata` byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_row | input | ROW_W | Row index of the load whose RAM read is launched this cycle |
| ram_rdata | input | 64 | Registered RAM output for the load launched last cycle |
| st_valid | input | 1 | A store hit is presented this cycle |
| st_row | input | ROW_W | Row index of the store |
| st_mask | input | 8 | Byte lane enables of the store, bit b for lane b |
| st_data | input | 64 | Store data, lane b at bits 8b+7..8b |
| ld_data | output | 64 | Load data with the forwarded bytes merged in |

## Verification
The load row is tried against a younger store alone, an older store alone, and both stores together. With both stores, overlapping masks show whether the younger byte takes priority, and disjoint masks show whether the lanes of the two stores combine. Negative patterns use a wrong row, a low valid, an all-zero mask and a store three cycles old. Each of them should give the raw word, which tells a real match apart from an over-eager comparator or a chain that is one stage too long. The raw word is also changed within a cycle with no match, which shows that the pass-through has no register in its path.

// File: rtl/slf_pkg.sv
package slf_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic       valid;
        lane_mask_t mask;
        word_t      data;
    } st_entry_t;

    // Overlay the lanes of fill selected by sel onto base.
    function automatic word_t lane_overlay(word_t base, word_t fill, lane_mask_t sel);
        word_t res;
        res = base;
        for (int b = 0; b < LANES; b++) begin
            if (sel[b]) res[b*LANE_W +: LANE_W] = fill[b*LANE_W +: LANE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/slf_store_chain.sv
module slf_store_chain
    import slf_pkg::*;
#(
    parameter int ROW_W      = 6,
    parameter int NUM_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  st_entry_t        in_ent,
    input  logic [ROW_W-1:0] in_row,
    output st_entry_t        ent [NUM_STAGES],
    output logic [ROW_W-1:0] row [NUM_STAGES]
);

    // Stage 0 is the youngest store; each edge moves entries one stage older.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[s] <= '0;
                row[s] <= '0;
            end else if (s == 0) begin
                ent[s] <= in_ent;
                row[s] <= in_row;
            end else begin
                ent[s] <= ent[s-1];
                row[s] <= row[s-1];
            end
        end
    end

endmodule

// File: rtl/slf_hit_detect.sv
module slf_hit_detect
    import slf_pkg::*;
#(
    parameter int ROW_W      = 6,
    parameter int NUM_STAGES = 2
) (
    input  st_entry_t        ent [NUM_STAGES],
    input  logic [ROW_W-1:0] row [NUM_STAGES],
    input  logic [ROW_W-1:0] load_row,
    output lane_mask_t       sel [NUM_STAGES]
);

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_cmp
        logic hit;
        assign hit    = ent[s].valid && (row[s] == load_row);
        assign sel[s] = hit ? ent[s].mask : '0;
    end

endmodule

// File: rtl/slf_lane_merge.sv
module slf_lane_merge
    import slf_pkg::*;
#(
    parameter int NUM_STAGES = 2
) (
    input  word_t      raw,
    input  st_entry_t  ent [NUM_STAGES],
    input  lane_mask_t sel [NUM_STAGES],
    output word_t      merged
);

    // Apply oldest first so younger stages overwrite shared lanes.
    always_comb begin
        merged = raw;
        for (int s = NUM_STAGES - 1; s >= 0; s--) begin
            merged = lane_overlay(merged, ent[s].data, sel[s]);
        end
    end

endmodule

// File: rtl/store_load_fwd.sv
module store_load_fwd
    import slf_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ROW_W-1:0]      ld_row,
    input  logic [WORD_W-1:0]     ram_rdata,
    input  logic                  st_valid,
    input  logic [ROW_W-1:0]      st_row,
    input  logic [LANES-1:0]      st_mask,
    input  logic [WORD_W-1:0]     st_data,
    output logic [WORD_W-1:0]     ld_data
);

    // One stage covers the registered read, one the late commit.
    localparam int NUM_STAGES = 2;

    st_entry_t        new_ent;
    st_entry_t        chain_ent [NUM_STAGES];
    logic [ROW_W-1:0] chain_row [NUM_STAGES];
    lane_mask_t       lane_sel  [NUM_STAGES];
    logic [ROW_W-1:0] load_row_q;

    assign new_ent = '{valid: st_valid, mask: st_mask, data: st_data};

    always_ff @(posedge clk) begin
        if (rst) load_row_q <= '0;
        else     load_row_q <= ld_row;
    end

    slf_store_chain #(.ROW_W(ROW_W), .NUM_STAGES(NUM_STAGES)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .in_ent (new_ent),
        .in_row (st_row),
        .ent    (chain_ent),
        .row    (chain_row)
    );

    slf_hit_detect #(.ROW_W(ROW_W), .NUM_STAGES(NUM_STAGES)) u_hit (
        .ent      (chain_ent),
        .row      (chain_row),
        .load_row (load_row_q),
        .sel      (lane_sel)
    );

    slf_lane_merge #(.NUM_STAGES(NUM_STAGES)) u_merge (
        .raw    (ram_rdata),
        .ent    (chain_ent),
        .sel    (lane_sel),
        .merged (ld_data)
    );

endmodule

// File: rtl/store_load_fwd_chk.sv
module store_load_fwd_chk
    import slf_pkg::*;
#(
    parameter int ROW_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ROW_W-1:0]  ld_row,
    input logic [WORD_W-1:0] ram_rdata,
    input logic              st_valid,
    input logic [ROW_W-1:0]  st_row,
    input logic [LANES-1:0]  st_mask,
    input logic [WORD_W-1:0] st_data,
    input logic [WORD_W-1:0] ld_data
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ld_data == ram_rdata)); // R1

    AST_NO_MATCH_PASS: assert property (@(posedge clk) disable iff (rst)
        (!($past(st_valid) && ($past(st_row) == $past(ld_row))) &&
         !($past(st_valid, 2) && ($past(st_row, 2) == $past(ld_row))))
        |-> (ld_data == ram_rdata)); // R2

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        AST_YOUNG_LANE: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(st_valid) && ($past(st_row) == $past(ld_row)) &&
             $past(st_mask[b]))
            |-> (ld_data[b*LANE_W +: LANE_W] == $past(st_data[b*LANE_W +: LANE_W]))); // R3

        AST_OLD_LANE: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(rst, 2) && $past(st_valid, 2) &&
             ($past(st_row, 2) == $past(ld_row)) && $past(st_mask[b], 2) &&
             !($past(st_valid) && ($past(st_row) == $past(ld_row)) && $past(st_mask[b])))
            |-> (ld_data[b*LANE_W +: LANE_W] == $past(st_data[b*LANE_W +: LANE_W], 2))); // R4
    end

endmodule

bind store_load_fwd store_load_fwd_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_row    (ld_row),
    .ram_rdata (ram_rdata),
    .st_valid  (st_valid),
    .st_row    (st_row),
    .st_mask   (st_mask),
    .st_data   (st_data),
    .ld_data   (ld_data)
);

// File: tb/store_load_fwd_tb.sv
module store_load_fwd_tb;
    import slf_pkg::*;

    localparam int ROW_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ROW_W-1:0] ld_row = '0;
    word_t            ram_rdata = '0;
    logic             st_valid = 1'b0;
    logic [ROW_W-1:0] st_row = '0;
    lane_mask_t       st_mask = '0;
    word_t            st_data = '0;
    word_t            ld_data;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    store_load_fwd #(.ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst(rst), .ld_row(ld_row), .ram_rdata(ram_rdata),
        .st_valid(st_valid), .st_row(st_row), .st_mask(st_mask),
        .st_data(st_data), .ld_data(ld_data)
    );

    function automatic word_t expect_word(word_t raw, word_t od, lane_mask_t om,
                                          word_t yd, lane_mask_t ym);
        word_t r = raw;
        for (int b = 0; b < LANES; b++) begin
            if (ym[b])      r[b*8 +: 8] = yd[b*8 +: 8];
            else if (om[b]) r[b*8 +: 8] = od[b*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(string req, word_t exp);
        n_run++;
        if (ld_data !== exp) begin
            n_fail++;
            $display("FAIL %s: ld_data=%h expected=%h", req, ld_data, exp);
        end
    endtask

    // One input cycle: store port plus load row.
    task automatic step(logic v, logic [ROW_W-1:0] r, lane_mask_t m, word_t d,
                        logic [ROW_W-1:0] lr);
        @(negedge clk);
        st_valid = v; st_row = r; st_mask = m; st_data = d; ld_row = lr;
    endtask

    // Output cycle of the load: supply raw RAM word, then check.
    task automatic observe(string req, word_t raw, word_t exp);
        @(negedge clk);
        st_valid = 1'b0;
        ram_rdata = raw;
        #1;
        check(req, exp);
    endtask

    localparam word_t RAW1 = 64'h1111_2222_3333_4444;
    localparam word_t DA   = 64'hA1A2_A3A4_A5A6_A7A8;
    localparam word_t DB   = 64'hB1B2_B3B4_B5B6_B7B8;

    task automatic t_reset();
        rst = 1'b1;
        step(1'b1, 6'd5, 8'hFF, DA, 6'd5);
        step(1'b1, 6'd5, 8'hFF, DB, 6'd5);
        @(negedge clk);
        rst = 1'b0; st_valid = 1'b0; ram_rdata = RAW1;
        #1; check("R1", RAW1);
    endtask

    task automatic t_pass();
        step(1'b0, 6'd0, 8'h00, '0, 6'd7);
        step(1'b0, 6'd0, 8'h00, '0, 6'd7);
        observe("R2", RAW1, RAW1);
        ram_rdata = 64'hDEAD_BEEF_0000_FFFF;
        #1; check("R2", 64'hDEAD_BEEF_0000_FFFF);
    endtask

    task automatic t_young();
        step(1'b0, 6'd0, 8'h00, '0, 6'd0);
        step(1'b1, 6'd9, 8'h0F, DA, 6'd9);
        observe("R3", RAW1, expect_word(RAW1, '0, 8'h00, DA, 8'h0F));
    endtask

    task automatic t_old();
        step(1'b1, 6'd9, 8'hF0, DB, 6'd0);
        step(1'b0, 6'd0, 8'h00, '0, 6'd9);
        observe("R4", RAW1, expect_word(RAW1, DB, 8'hF0, '0, 8'h00));
    endtask

    task automatic t_priority();
        step(1'b1, 6'd3, 8'hFF, DA, 6'd0);
        step(1'b1, 6'd3, 8'h3C, DB, 6'd3);
        observe("R5", RAW1, expect_word(RAW1, DA, 8'hFF, DB, 8'h3C));
        step(1'b1, 6'd4, 8'h0F, DA, 6'd0);
        step(1'b1, 6'd4, 8'hC0, DB, 6'd4);
        observe("R5", RAW1, expect_word(RAW1, DA, 8'h0F, DB, 8'hC0));
    endtask

    task automatic t_row_miss();
        step(1'b1, 6'd12, 8'hFF, DA, 6'd0);
        step(1'b1, 6'd12, 8'hFF, DB, 6'd11);
        observe("R6", RAW1, RAW1);
        step(1'b1, 6'd20, 8'h0F, DA, 6'd0);
        step(1'b1, 6'd21, 8'hFF, DB, 6'd20);
        observe("R6", RAW1, expect_word(RAW1, DA, 8'h0F, '0, 8'h00));
    endtask

    task automatic t_invalid();
        step(1'b0, 6'd14, 8'hFF, DA, 6'd0);
        step(1'b0, 6'd14, 8'hFF, DB, 6'd14);
        observe("R7", RAW1, RAW1);
    endtask

    task automatic t_stale();
        step(1'b1, 6'd30, 8'hFF, DA, 6'd0);
        step(1'b0, 6'd0, 8'h00, '0, 6'd0);
        step(1'b0, 6'd0, 8'h00, '0, 6'd30);
        observe("R8", RAW1, RAW1);
    endtask

    task automatic t_zero_mask();
        step(1'b1, 6'd40, 8'h00, DA, 6'd0);
        step(1'b1, 6'd40, 8'h00, DB, 6'd40);
        observe("R9", RAW1, RAW1);
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pass();
        t_young();
        t_old();
        t_priority();
        t_row_miss();
        t_invalid();
        t_stale();
        t_zero_mask();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule